// File: doc/BRIEF.md
# Dual-table piecewise gamma corrector

This block converts a stream of 12-bit linear pixel samples into 8-bit display-ready codes. It follows a piecewise-linear transfer curve with 19 knots at fixed, unevenly spaced input positions. The segments are narrow near black and wider above. The output value of each knot is programmable. Two independent knot tables are kept: one tuned for well-lit scenes and one for dim scenes.

A curve-mode control selects the curve. It can be the bright table alone, the dark table alone, or a per-knot blend of the two. An 8-bit brightness weight steers the blend, and logic outside this block supplies that weight. Knot writes, mode changes and weight changes are staged. They reach the pixel path only on a frame-start pulse, so every pixel of one frame sees the same curve.

The path accepts one pixel per clock. Each pixel comes out exactly three clocks after it enters, with its valid flag carried alongside.

Top module: `gamma_blend_top`

## Requirements
- R1: After reset `pix_valid_o` is 0 and `pix_o` is 0. Both active tables hold all-zero knots, the active mode is bright-only and the active weight is 0, so every pixel maps to 0 until the first frame-start pulse.
- R2: Knot k lies at input 64·k for k = 0..2 and at 256·(k−2) for k = 3..18, so the knot inputs are 0, 64, 128, 256, 512, …, 4096. An input equal to a knot position produces that knot's active output value.
- R3: For an input x in the segment from knot k (position xk, value yk) to knot k+1 (value yk1), with segment width W (64, 64, 128, then 256), the output is yk + floor(((yk1−yk)·(x−xk) + W/2) / W). The result is clamped to 0..255. Input 4095 lies in the last segment.
- R4: A write with `cfg_we`=1 stores `cfg_data` as the knot value at index `cfg_addr` (0..18). `cfg_bank`=0 selects the bright table and `cfg_bank`=1 selects the dark table. Writes with `cfg_addr` 19..31 have no effect.
- R5: Curve-mode code 0 uses the bright table only and code 1 uses the dark table only. Codes 2 and 3 both use the blended table.
- R6: In blend mode each knot value is (w·bright + (256−w)·dark + 128) / 256, rounded down, where w is the active weight.
- R7: Knot writes and changes on `curve_mode_i` or `blend_wgt_i` do not affect the output until a cycle with `frame_start` high. On that edge the staged tables, mode and weight become active together.
- R8: A pixel presented with `pix_valid_i` high appears on `pix_o` with `pix_valid_o` high exactly 3 clock cycles later. Back-to-back pixels are accepted on every cycle.
- R9: While `pix_valid_o` is low, `pix_o` keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse that makes staged settings active |
| pix_valid_i | input | 1 | Input sample qualifier |
| pix_i | input | 12 | Linear input sample |
| cfg_we | input | 1 | Knot write strobe |
| cfg_bank | input | 1 | Table select: 0 bright, 1 dark |
| cfg_addr | input | 5 | Knot index |
| cfg_data | input | 8 | Knot output value |
| curve_mode_i | input | 2 | Curve mode code, staged |
| blend_wgt_i | input | 8 | Brightness weight toward the bright table, staged |
| pix_valid_o | output | 1 | Output sample qualifier |
| pix_o | output | 8 | Corrected output sample |

## Verification
The bench uses two tables with different shapes: the bright table rises in steps of 14 and the dark table falls in steps of 13. Every interpolated segment therefore has both positive and negative slopes, which exposes sign and rounding errors in the interpolation step.

One set of inputs covers each segment width, every knot position, mid-segment points and the top code 4095. This set is replayed under bright-only, dark-only and blend modes with several weights. A mix-up of tables, a wrong blend weighting or a wrong segment boundary gives a different value for at least one of these inputs.

Two cases are sent while staged settings differ from the active ones: knot writes mid-frame, and mode or weight changes without a frame-start pulse. These cases show whether settings leak into the pixel path early. Writes to out-of-range knot indices, followed by a frame-start pulse, show whether they disturb the tables.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int PIX_W  = 12;
    localparam int OUT_W  = 8;
    localparam int KNOTS  = 19;
    localparam int WGT_W  = 8;
    localparam int SEG_W  = $clog2(KNOTS);
    localparam int FRAC_W = 8;
    localparam int SHF_W  = 4;
    localparam int LAST_SEG = KNOTS - 2;

    typedef logic [OUT_W-1:0] knot_t;

    typedef enum logic [1:0] {
        MODE_BRIGHT  = 2'd0,
        MODE_DARK    = 2'd1,
        MODE_MIX     = 2'd2,
        MODE_MIX_ALT = 2'd3
    } curve_mode_e;

    typedef struct packed {
        logic [SEG_W-1:0]  seg;
        logic [FRAC_W-1:0] frac;
        logic [SHF_W-1:0]  shift;
    } seg_info_t;

    typedef struct packed {
        logic              vld;
        logic [SEG_W-1:0]  seg;
        knot_t             b_lo;
        knot_t             b_hi;
        knot_t             d_lo;
        knot_t             d_hi;
        logic [FRAC_W-1:0] frac;
        logic [SHF_W-1:0]  shift;
        curve_mode_e       mode;
        logic [WGT_W-1:0]  wgt;
    } fetch_t;

    typedef struct packed {
        logic              vld;
        knot_t             y_lo;
        knot_t             y_hi;
        logic [FRAC_W-1:0] frac;
        logic [SHF_W-1:0]  shift;
    } blend_t;
endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
    import gamma_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    output seg_info_t        info
);
    always_comb begin
        info = '0;
        if (pix[PIX_W-1:8] != '0) begin
            info.seg   = SEG_W'(pix[PIX_W-1:8]) + SEG_W'(2);
            info.frac  = pix[7:0];
            info.shift = SHF_W'(8);
        end else if (pix[7]) begin
            info.seg   = SEG_W'(2);
            info.frac  = {1'b0, pix[6:0]};
            info.shift = SHF_W'(7);
        end else begin
            info.seg   = SEG_W'(pix[6]);
            info.frac  = {2'b00, pix[5:0]};
            info.shift = SHF_W'(6);
        end
    end
endmodule

// File: rtl/gamma_knot_bank.sv
module gamma_knot_bank
    import gamma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             we,
    input  logic             bank,
    input  logic [4:0]       addr,
    input  knot_t            data,
    input  logic [1:0]       mode_in,
    input  logic [WGT_W-1:0] wgt_in,
    output knot_t            act_b [KNOTS],
    output knot_t            act_d [KNOTS],
    output curve_mode_e      act_mode,
    output logic [WGT_W-1:0] act_wgt
);
    knot_t stg_b [KNOTS];
    knot_t stg_d [KNOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < KNOTS; k++) begin
                stg_b[k] <= '0;
                stg_d[k] <= '0;
                act_b[k] <= '0;
                act_d[k] <= '0;
            end
            act_mode <= MODE_BRIGHT;
            act_wgt  <= '0;
        end else begin
            for (int k = 0; k < KNOTS; k++) begin
                if (we && (addr == 5'(k))) begin
                    if (bank) stg_d[k] <= data;
                    else      stg_b[k] <= data;
                end
                if (frame_start) begin
                    act_b[k] <= stg_b[k];
                    act_d[k] <= stg_d[k];
                end
            end
            if (frame_start) begin
                act_mode <= curve_mode_e'(mode_in);
                act_wgt  <= wgt_in;
            end
        end
    end
endmodule

// File: rtl/gamma_knot_mix.sv
module gamma_knot_mix
    import gamma_pkg::*;
(
    input  knot_t            b,
    input  knot_t            d,
    input  logic [WGT_W-1:0] w,
    input  curve_mode_e      mode,
    output knot_t            y
);
    localparam int ACC_W = OUT_W + WGT_W + 1;
    localparam int ONE   = 1 << WGT_W;
    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(w) * ACC_W'(b)
            + (ACC_W'(ONE) - ACC_W'(w)) * ACC_W'(d)
            + ACC_W'(ONE / 2);
        unique case (mode)
            MODE_BRIGHT: y = b;
            MODE_DARK:   y = d;
            default:     y = acc[WGT_W +: OUT_W];
        endcase
    end
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
    import gamma_pkg::*;
(
    input  knot_t             y_lo,
    input  knot_t             y_hi,
    input  logic [FRAC_W-1:0] frac,
    input  logic [SHF_W-1:0]  shift,
    output knot_t             y
);
    localparam int DW = OUT_W + 2;
    localparam int PW = DW + FRAC_W + 1;
    logic signed [DW-1:0] diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] half;
    logic signed [PW-1:0] q;
    logic signed [DW:0]   sum;

    always_comb begin
        diff = $signed({2'b00, y_hi}) - $signed({2'b00, y_lo});
        prod = PW'(diff) * PW'($signed({1'b0, frac}));
        half = PW'(1) <<< (shift - SHF_W'(1));
        q    = (prod + half) >>> shift;
        sum  = $signed({3'b000, y_lo}) + q[DW:0];
        if (sum < 0)
            y = '0;
        else if (sum > $signed((DW+1)'((1 << OUT_W) - 1)))
            y = '1;
        else
            y = sum[OUT_W-1:0];
    end
endmodule

// File: rtl/gamma_blend_top.sv
module gamma_blend_top
    import gamma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             pix_valid_i,
    input  logic [11:0]      pix_i,
    input  logic             cfg_we,
    input  logic             cfg_bank,
    input  logic [4:0]       cfg_addr,
    input  logic [7:0]       cfg_data,
    input  logic [1:0]       curve_mode_i,
    input  logic [7:0]       blend_wgt_i,
    output logic             pix_valid_o,
    output logic [7:0]       pix_o
);
    knot_t            act_b [KNOTS];
    knot_t            act_d [KNOTS];
    curve_mode_e      act_mode;
    logic [WGT_W-1:0] act_wgt;
    seg_info_t        dec;
    logic [SEG_W-1:0] seg_hi;
    fetch_t           s1;
    blend_t           s2;
    knot_t            mix_y [2];
    knot_t            out_y;

    gamma_knot_bank u_bank (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .we(cfg_we), .bank(cfg_bank), .addr(cfg_addr), .data(cfg_data),
        .mode_in(curve_mode_i), .wgt_in(blend_wgt_i),
        .act_b(act_b), .act_d(act_d), .act_mode(act_mode), .act_wgt(act_wgt)
    );

    gamma_seg_decode u_dec (.pix(pix_i), .info(dec));
    assign seg_hi = dec.seg + SEG_W'(1);

    // stage 1: segment decode and knot fetch, curve settings travel with pixel
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld   <= pix_valid_i;
            s1.seg   <= dec.seg;
            s1.b_lo  <= act_b[dec.seg];
            s1.b_hi  <= act_b[seg_hi];
            s1.d_lo  <= act_d[dec.seg];
            s1.d_hi  <= act_d[seg_hi];
            s1.frac  <= dec.frac;
            s1.shift <= dec.shift;
            s1.mode  <= act_mode;
            s1.wgt   <= act_wgt;
        end
    end

    // stage 2: blend both segment endpoints
    for (genvar e = 0; e < 2; e++) begin : g_end
        gamma_knot_mix u_mix (
            .b   (e == 0 ? s1.b_lo : s1.b_hi),
            .d   (e == 0 ? s1.d_lo : s1.d_hi),
            .w   (s1.wgt),
            .mode(s1.mode),
            .y   (mix_y[e])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld   <= s1.vld;
            s2.y_lo  <= mix_y[0];
            s2.y_hi  <= mix_y[1];
            s2.frac  <= s1.frac;
            s2.shift <= s1.shift;
        end
    end

    // stage 3: interpolate inside the segment and clamp
    gamma_interp u_interp (
        .y_lo(s2.y_lo), .y_hi(s2.y_hi), .frac(s2.frac), .shift(s2.shift), .y(out_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid_o <= 1'b0;
            pix_o       <= '0;
        end else begin
            pix_valid_o <= s2.vld;
            if (s2.vld) pix_o <= out_y;
        end
    end
endmodule

// File: rtl/gamma_blend_chk.sv
module gamma_blend_chk
    import gamma_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_start,
    input logic             pix_valid_i,
    input logic             pix_valid_o,
    input logic [7:0]       pix_o,
    input logic [1:0]       act_mode,
    input logic [WGT_W-1:0] act_wgt,
    input logic             s1_vld,
    input logic [SEG_W-1:0] s1_seg
);
    logic [1:0] up_cnt;

    always_ff @(posedge clk) begin
        if (rst)                up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cnt == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3)));

    // R9
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (up_cnt != 2'd0 && !pix_valid_o) |-> $stable(pix_o));

    // R7
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act_mode));

    // R7
    wgt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act_wgt));

    // R2
    seg_range_chk: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> (s1_seg <= SEG_W'(LAST_SEG)));
endmodule

bind gamma_blend_top gamma_blend_chk chk_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .pix_valid_i(pix_valid_i), .pix_valid_o(pix_valid_o), .pix_o(pix_o),
    .act_mode(act_mode), .act_wgt(act_wgt),
    .s1_vld(s1.vld), .s1_seg(s1.seg)
);

// File: tb/gamma_blend_top_tb_top.sv
module gamma_blend_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [11:0] pix_i = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_bank = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic [1:0]  curve_mode_i = '0;
    logic [7:0]  blend_wgt_i = '0;
    logic        pix_valid_o;
    logic [7:0]  pix_o;

    int checks = 0;
    int bad = 0;
    int sh_b [19];
    int sh_d [19];
    int ac_b [19];
    int ac_d [19];
    int ac_mode = 0;
    int ac_w = 0;

    localparam int NV = 14;
    // each entry: {mode, weight, pixel}
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 8'd0,   12'd0},    {2'd0, 8'd0,   12'd37},
        {2'd1, 8'd0,   12'd64},   {2'd1, 8'd0,   12'd100},
        {2'd1, 8'd0,   12'd191},  {2'd0, 8'd0,   12'd300},
        {2'd2, 8'd64,  12'd128},  {2'd2, 8'd64,  12'd255},
        {2'd2, 8'd64,  12'd1000}, {2'd2, 8'd200, 12'd2048},
        {2'd2, 8'd200, 12'd3000}, {2'd3, 8'd200, 12'd4095},
        {2'd2, 8'd1,   12'd777},  {2'd3, 8'd255, 12'd3900}
    };

    gamma_blend_top dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .pix_valid_i(pix_valid_i), .pix_i(pix_i),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .curve_mode_i(curve_mode_i), .blend_wgt_i(blend_wgt_i),
        .pix_valid_o(pix_valid_o), .pix_o(pix_o)
    );

    always #5 clk = ~clk;

    initial begin
        #1_000_000;
        bad++;
        checks++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    function automatic int kx(int k);
        return (k < 3) ? k * 64 : (k - 2) * 256;
    endfunction

    function automatic int mixk(int b, int d);
        if (ac_mode == 0) return b;
        if (ac_mode == 1) return d;
        return (ac_w * b + (256 - ac_w) * d + 128) / 256;
    endfunction

    function automatic int model(int px);
        int seg, x0, wd, f, y0, y1, num, q, o;
        if (px >= 256)      seg = px / 256 + 2;
        else if (px >= 128) seg = 2;
        else if (px >= 64)  seg = 1;
        else                seg = 0;
        x0 = kx(seg);
        wd = kx(seg + 1) - x0;
        f  = px - x0;
        y0 = mixk(ac_b[seg], ac_d[seg]);
        y1 = mixk(ac_b[seg + 1], ac_d[seg + 1]);
        num = (y1 - y0) * f + wd / 2;
        q = (num >= 0) ? num / wd : -((-num + wd - 1) / wd);
        o = y0 + q;
        if (o < 0) o = 0;
        if (o > 255) o = 255;
        return o;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_knot(bit bank, int addr, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_addr = 5'(addr); cfg_data = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < 19) begin
            if (bank) sh_d[addr] = val;
            else      sh_b[addr] = val;
        end
    endtask

    task automatic frame_pulse(int mode, int w);
        @(negedge clk);
        curve_mode_i = 2'(mode); blend_wgt_i = 8'(w); frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < 19; k++) begin
            ac_b[k] = sh_b[k];
            ac_d[k] = sh_d[k];
        end
        ac_mode = mode;
        ac_w = w;
    endtask

    task automatic one_pixel(string req, int px);
        @(negedge clk);
        pix_valid_i = 1'b1; pix_i = 12'(px);
        @(negedge clk);
        pix_valid_i = 1'b0;
        @(negedge clk);
        check({req, " valid early"}, int'(pix_valid_o), 0);
        @(negedge clk);
        check({req, " valid"}, int'(pix_valid_o), 1);
        check(req, int'(pix_o), model(px));
    endtask

    initial begin
        for (int k = 0; k < 19; k++) begin
            sh_b[k] = 0; sh_d[k] = 0; ac_b[k] = 0; ac_d[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid after reset", int'(pix_valid_o), 0);
        check("R1 pix after reset", int'(pix_o), 0);
        one_pixel("R1 zero curve", 2048);

        for (int k = 0; k < 19; k++) begin
            write_knot(1'b0, k, k * 14);
            write_knot(1'b1, k, 255 - k * 13);
        end
        // R7: staged writes not visible before frame start
        one_pixel("R7 writes staged", 3000);

        frame_pulse(0, 0);
        // R2: knot positions give knot values
        for (int k = 0; k < 18; k++) begin
            checks++;
            if (model(kx(k)) != k * 14) begin
                bad++;
                $display("FAIL R2 bench model: actual=%0d expected=%0d", model(kx(k)), k * 14);
            end
            one_pixel("R2 knot", kx(k));
        end
        one_pixel("R3 top code", 4095);

        // vector walk: modes, weights, segments (R3 R5 R6), back-to-back (R8)
        for (int v = 0; v < NV; v++) begin
            int pv;
            pv = int'(VEC[v][11:0]);
            frame_pulse(int'(VEC[v][21:20]), int'(VEC[v][19:12]));
            one_pixel("R5 R6 R3 vector", pv);
        end

        frame_pulse(2, 77);
        begin
            int exp_q [NV];
            for (int i = 0; i < NV + 3; i++) begin
                @(negedge clk);
                if (i >= 3) begin
                    check("R8 stream valid", int'(pix_valid_o), 1);
                    check("R8 stream data", int'(pix_o), exp_q[i - 3]);
                end
                if (i < NV) begin
                    pix_valid_i = 1'b1;
                    pix_i = VEC[i][11:0];
                    exp_q[i] = model(int'(VEC[i][11:0]));
                end else begin
                    pix_valid_i = 1'b0;
                end
            end
        end

        // R9: output holds while idle
        begin
            int held;
            held = int'(pix_o);
            repeat (5) @(negedge clk);
            check("R9 hold valid", int'(pix_valid_o), 0);
            check("R9 hold data", int'(pix_o), held);
        end

        // R4: out-of-range addresses ignored
        write_knot(1'b0, 19, 200);
        write_knot(1'b1, 25, 3);
        write_knot(1'b0, 31, 99);
        frame_pulse(0, 0);
        one_pixel("R4 ignored addr bright", 4095);
        frame_pulse(1, 0);
        one_pixel("R4 ignored addr dark", 4000);

        // R7: mode and weight change without frame start
        @(negedge clk);
        curve_mode_i = 2'd0; blend_wgt_i = 8'd255;
        one_pixel("R7 mode staged", 1500);
        write_knot(1'b1, 7, 0);
        one_pixel("R7 knot staged", 1300);
        frame_pulse(0, 255);
        one_pixel("R7 after frame start", 1300);
        frame_pulse(1, 0);
        one_pixel("R7 new knot active", 1300);

        // R5: mode 3 equals mode 2
        frame_pulse(3, 128);
        one_pixel("R5 mode3 blend", 2600);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule